// File: doc/BRIEF.md
# Multi-Rate Event Scheduler Sequencer

This block walks a schedule table that sits in external word-addressed memory. The table is organised as frames of 8, 16 or 32 entries. The walker fetches every entry of every frame in order. The fetch is needed because the active bit is only known once the word has been read. Each active entry is presented as a transmit event on a valid/ready output.

Frames are grouped into turns of two kinds, each with its own last-frame number. A long turn covers frames 0 to the long end. A short turn covers frames 0 to the short end. A ratio register sets how many long turns run before each short turn.

The sequencer runs while an enable bit is set. An overload sets a sticky fatal flag. Overload means an active entry arrives while the previous event is still stalled at the output. An illegal configuration is refused at enable time and sets a second sticky flag. A service bit in the status word shows whether either flag is set.

Top module: `evsched_seq`

## Requirements
- R1: After reset, every register reads 0, `mem_rd` is 0 and `ev_valid` is 0.
- R2: Table register (index 2) bits 13:12 select the entries per frame: code 0 gives 8, code 1 gives 16 and code 2 gives 32.
- R3: The fetch word address is (table register bits 11:0) × 512 + frame × entries + entry index. Entries are fetched in increasing index order within each frame.
- R4: Frame limits come from the end-frame register (index 3). A long turn fetches frames 0 through bits 15:8. A short turn fetches frames 0 through bits 7:0.
- R5: The ratio register (index 4, bits 2:0) holds a value N from {1, 3, 7}. With such an N, the turns repeat as N long turns followed by one short turn. With N = 0, only long turns run.
- R6: At most one read is outstanding. `mem_rd` is a single-cycle strobe and is never raised again before the previous `mem_rvalid`.
- R7: A fetched word with bit 15 set puts its bits 14:0 on `ev_data` with `ev_valid`. The event is held stable until `ev_ready`. Inactive words produce no event.
- R8: An active word fetched while the output is stalled is dropped and sets status bit 0. The bit stays set until a 1 is written to status bit 0.
- R9: Status (index 1) bit 15 reads 1 exactly when status bit 0 or bit 1 is set.
- R10: Writing 1 to control (index 0) bit 0 is refused when the entries code is 3 or the ratio is 2, 4, 5 or 6. A refused enable leaves the enable bit at 0, issues no fetch, and sets sticky status bit 1, which is cleared by writing 1 to it.
- R11: Writes to the table, end-frame and ratio registers are ignored while enabled.
- R12: Enabling starts at frame 0, entry 0 of a long turn with the long-turn count cleared. Clearing the enable stops the fetches once the read in progress has returned, with at most one further read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 21 | Memory word address |
| mem_rdata | input | 16 | Memory read data |
| mem_rvalid | input | 1 | Memory read data valid |
| ev_valid | output | 1 | Event valid |
| ev_data | output | 15 | Event payload |
| ev_ready | input | 1 | Event accepted by consumer |

## Verification
A register write lands at the next clock edge, and register reads are combinational. The bench therefore reads back one falling edge after a write. An accepted enable raises `mem_rd` two edges later. A returned word drives `ev_valid` one edge after `mem_rvalid`, and the overload flag sets at that same edge. The bench's memory model answers one cycle after each strobe. At every falling edge it compares each strobed address against an arithmetic turn/frame/entry model, and it compares each accepted event against a queue filled from that model. Status and hold checks are taken only after enough edges have passed for the flag or output to have settled.

// File: rtl/evsched_pkg.sv
package evsched_pkg;
  localparam int DW      = 16;
  localparam int EV_W    = DW - 1;
  localparam int MEM_AW  = 21;
  localparam int BASE_W  = 12;
  localparam int BASE_SH = MEM_AW - BASE_W;
  localparam int FRAME_W = 8;
  localparam int RATIO_W = 3;
  localparam int CODE_W  = 2;
  localparam int IDX_W   = 5;
  localparam int REG_AW  = 3;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] RA_TABLE = 3'd2;
  localparam logic [REG_AW-1:0] RA_ENDS  = 3'd3;
  localparam logic [REG_AW-1:0] RA_RATIO = 3'd4;

  typedef enum logic [1:0] {WS_IDLE, WS_ISSUE, WS_WAIT} walk_st_t;

  typedef struct packed {
    logic [BASE_W-1:0]  base;
    logic [CODE_W-1:0]  code;
    logic [FRAME_W-1:0] short_end;
    logic [FRAME_W-1:0] long_end;
    logic [RATIO_W-1:0] ratio;
  } sched_cfg_t;
endpackage

// File: rtl/evsched_regs.sv
module evsched_regs
  import evsched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              ovl_set,
  output logic              run_en,
  output logic              ovl_err,
  output logic              cfg_err,
  output sched_cfg_t        cfg
);
  sched_cfg_t cfg_q, cfg_d;
  logic en_q, en_d, ovl_q, ovl_d, cerr_q, cerr_d, cerr_set, cfg_ok, cfg_we;
  logic wr_ctrl, wr_stat, wr_tbl, wr_end, wr_rat;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_tbl  = reg_wr && (reg_addr == RA_TABLE);
  assign wr_end  = reg_wr && (reg_addr == RA_ENDS);
  assign wr_rat  = reg_wr && (reg_addr == RA_RATIO);
  assign cfg_we  = !en_q && (wr_tbl || wr_end || wr_rat);

  // legal ratio values are of the form 2^k - 1
  assign cfg_ok = (cfg_q.code != 2'd3) &&
                  ((cfg_q.ratio & (cfg_q.ratio + 3'd1)) == '0);

  always_comb begin
    cfg_d    = cfg_q;
    en_d     = en_q;
    cerr_set = 1'b0;
    if (wr_ctrl) begin
      if (reg_wdata[0]) begin
        if (cfg_ok) en_d = 1'b1;
        else        cerr_set = 1'b1;
      end else begin
        en_d = 1'b0;
      end
    end
    if (wr_tbl) begin
      cfg_d.base = reg_wdata[BASE_W-1:0];
      cfg_d.code = reg_wdata[BASE_W+CODE_W-1:BASE_W];
    end
    if (wr_end) begin
      cfg_d.short_end = reg_wdata[FRAME_W-1:0];
      cfg_d.long_end  = reg_wdata[2*FRAME_W-1:FRAME_W];
    end
    if (wr_rat) cfg_d.ratio = reg_wdata[RATIO_W-1:0];
    ovl_d  = (ovl_q  & ~(wr_stat & reg_wdata[0])) | ovl_set;
    cerr_d = (cerr_q & ~(wr_stat & reg_wdata[1])) | cerr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      ovl_q  <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_d;
      en_q   <= en_d;
      ovl_q  <= ovl_d;
      cerr_q <= cerr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL:  reg_rdata[0] = en_q;
      RA_STAT:  begin
        reg_rdata[0]    = ovl_q;
        reg_rdata[1]    = cerr_q;
        reg_rdata[DW-1] = ovl_q | cerr_q;
      end
      RA_TABLE: reg_rdata[BASE_W+CODE_W-1:0] = {cfg_q.code, cfg_q.base};
      RA_ENDS:  reg_rdata = {cfg_q.long_end, cfg_q.short_end};
      RA_RATIO: reg_rdata[RATIO_W-1:0] = cfg_q.ratio;
      default:  reg_rdata = '0;
    endcase
  end

  assign run_en  = en_q;
  assign ovl_err = ovl_q;
  assign cfg_err = cerr_q;
  assign cfg     = cfg_q;
endmodule

// File: rtl/evsched_walker.sv
module evsched_walker
  import evsched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  sched_cfg_t        cfg,
  input  logic              mem_rvalid,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              entry_done
);
  walk_st_t st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d, idx_last;
  logic [FRAME_W-1:0] frame_q, frame_d, frame_last;
  logic [RATIO_W-1:0] lc_q, lc_d;
  logic               short_q, short_d, cnt_we;
  logic [2:0]         shamt;

  always_comb begin
    unique case (cfg.code)
      2'd0:    idx_last = IDX_W'(7);
      2'd1:    idx_last = IDX_W'(15);
      default: idx_last = IDX_W'(31);
    endcase
  end

  assign frame_last = short_q ? cfg.short_end : cfg.long_end;
  assign entry_done = (st_q == WS_WAIT) && mem_rvalid;
  assign mem_rd     = (st_q == WS_ISSUE);
  assign shamt      = {1'b0, cfg.code} + 3'd3;
  assign mem_addr   = {cfg.base, BASE_SH'(0)}
                    + (MEM_AW'(frame_q) << shamt)
                    + MEM_AW'(idx_q);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    frame_d = frame_q;
    lc_d    = lc_q;
    short_d = short_q;
    cnt_we  = 1'b0;
    unique case (st_q)
      WS_IDLE: if (run_en) begin
        st_d    = WS_ISSUE;
        cnt_we  = 1'b1;
        idx_d   = '0;
        frame_d = '0;
        lc_d    = '0;
        short_d = 1'b0;
      end
      WS_ISSUE: st_d = WS_WAIT;
      WS_WAIT: if (mem_rvalid) begin
        st_d   = run_en ? WS_ISSUE : WS_IDLE;
        cnt_we = 1'b1;
        if (idx_q != idx_last) begin
          idx_d = idx_q + 1'b1;
        end else begin
          idx_d = '0;
          if (frame_q != frame_last) begin
            frame_d = frame_q + 1'b1;
          end else begin
            frame_d = '0;
            if (short_q) begin
              short_d = 1'b0;
              lc_d    = '0;
            end else if (cfg.ratio != '0) begin
              if (lc_q == cfg.ratio - 1'b1) begin
                short_d = 1'b1;
                lc_d    = '0;
              end else begin
                lc_d = lc_q + 1'b1;
              end
            end
          end
        end
      end
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      idx_q   <= '0;
      frame_q <= '0;
      lc_q    <= '0;
      short_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cnt_we) begin
        idx_q   <= idx_d;
        frame_q <= frame_d;
        lc_q    <= lc_d;
        short_q <= short_d;
      end
    end
  end
endmodule

// File: rtl/evsched_evout.sv
module evsched_evout
  import evsched_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry_done,
  input  logic [DW-1:0]   entry_word,
  input  logic            ev_ready,
  output logic            ev_valid,
  output logic [EV_W-1:0] ev_data,
  output logic            ovl_set
);
  logic            vld_q, vld_d, act, stalled, data_we;
  logic [EV_W-1:0] data_q;

  assign act     = entry_done && entry_word[DW-1];
  assign stalled = vld_q && !ev_ready;
  assign ovl_set = act && stalled;
  assign data_we = act && !stalled;

  always_comb begin
    vld_d = vld_q;
    if (data_we)              vld_d = 1'b1;
    else if (vld_q && ev_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (data_we) data_q <= entry_word[EV_W-1:0];
    end
  end

  assign ev_valid = vld_q;
  assign ev_data  = data_q;
endmodule

// File: rtl/evsched_seq.sv
module evsched_seq
  import evsched_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_rd,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rvalid,
  output logic              ev_valid,
  output logic [EV_W-1:0]   ev_data,
  input  logic              ev_ready
);
  logic [1:0] rs_q;
  logic       rst_s, run_en, ovl_err, cfg_err, ovl_set, entry_done;
  sched_cfg_t cfg;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  evsched_regs regs_i (
    .clk(clk), .rst_n(rst_s), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovl_set(ovl_set),
    .run_en(run_en), .ovl_err(ovl_err), .cfg_err(cfg_err), .cfg(cfg)
  );

  evsched_walker walk_i (
    .clk(clk), .rst_n(rst_s), .run_en(run_en), .cfg(cfg),
    .mem_rvalid(mem_rvalid), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .entry_done(entry_done)
  );

  evsched_evout evout_i (
    .clk(clk), .rst_n(rst_s), .entry_done(entry_done), .entry_word(mem_rdata),
    .ev_ready(ev_ready), .ev_valid(ev_valid), .ev_data(ev_data),
    .ovl_set(ovl_set)
  );
endmodule

// File: rtl/evsched_seq_chk.sv
module evsched_seq_chk
  import evsched_pkg::*;
(
  input logic              clk,
  input logic              rst_s,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DW-1:0]     reg_wdata,
  input logic [DW-1:0]     reg_rdata,
  input logic              mem_rd,
  input logic              mem_rvalid,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic [EV_W-1:0]   ev_data,
  input logic              run_en,
  input logic              ovl_err,
  input logic              cfg_err,
  input sched_cfg_t        cfg
);
  logic outst_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)          outst_q <= 1'b0;
    else if (mem_rd)     outst_q <= 1'b1;
    else if (mem_rvalid) outst_q <= 1'b0;
  end

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_s)
    mem_rd |=> !mem_rd);
  a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_s)
    mem_rd |-> !outst_q);
  a_r7_event_held: assert property (@(posedge clk) disable iff (!rst_s)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_data)));
  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    (ovl_err && !(reg_wr && reg_addr == RA_STAT && reg_wdata[0])) |=> ovl_err);
  a_r9_service_bit: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_addr == RA_STAT) |-> (reg_rdata[DW-1] == (ovl_err || cfg_err)));
  a_r11_cfg_locked: assert property (@(posedge clk) disable iff (!rst_s)
    (run_en && reg_wr) |=> $stable(cfg));
  a_r12_fetch_needs_en: assert property (@(posedge clk) disable iff (!rst_s)
    mem_rd |-> $past(run_en));
endmodule

bind evsched_seq evsched_seq_chk chk_i (.*);

// File: tb/evsched_seq_tb.sv
`timescale 1ns/1ps
module evsched_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        mem_rd;
  logic [20:0] mem_addr;
  logic [15:0] mem_rdata = 16'd0;
  logic        mem_rvalid = 1'b0;
  logic        ev_valid;
  logic [14:0] ev_data;
  logic        ev_ready = 1'b1;

  int  n_chk = 0, n_err = 0, rd_count = 0;
  bit  all_active = 1'b0, chk_ev = 1'b1, finished = 1'b0;
  int  m_base, m_epf, m_le, m_se, m_ratio, m_idx, m_frame, m_lc;
  bit  m_short;
  logic [14:0] evq [0:4095];
  int  qh = 0, qt = 0;

  always #2.5 clk = ~clk;

  evsched_seq dut_i (.*);

  function automatic bit is_act(input logic [20:0] a);
    return all_active || (a[1:0] == 2'b01);
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_rd;
    mem_rdata  <= {is_act(mem_addr), mem_addr[14:0]};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model_addr();
    return m_base * 512 + m_frame * m_epf + m_idx;
  endfunction

  task automatic model_step();
    int fend;
    fend = m_short ? m_se : m_le;
    if (m_idx < m_epf - 1) m_idx++;
    else begin
      m_idx = 0;
      if (m_frame < fend) m_frame++;
      else begin
        m_frame = 0;
        if (m_short) begin m_short = 0; m_lc = 0; end
        else if (m_ratio != 0) begin
          m_lc++;
          if (m_lc == m_ratio) begin m_short = 1; m_lc = 0; end
        end
      end
    end
  endtask

  task automatic model_start(input int base, input int code, input int le,
                             input int se, input int ratio);
    m_base = base; m_epf = 8 << code; m_le = le; m_se = se; m_ratio = ratio;
    m_idx = 0; m_frame = 0; m_lc = 0; m_short = 0;
    qh = 0; qt = 0; rd_count = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_rd) begin
      int e;
      e = model_addr();
      chk(mem_addr == 21'(e), "R2 R3 R4 R5 R12 fetch address", int'(mem_addr), e);
      if (is_act(21'(e))) begin evq[qt] = 15'(e); qt++; end
      model_step();
      rd_count++;
    end
    if (rst_n && chk_ev && ev_valid && ev_ready) begin
      if (qh < qt) begin
        chk(ev_data == evq[qh], "R7 event payload", int'(ev_data), int'(evq[qh]));
        qh++;
      end else chk(1'b0, "R7 unexpected event", int'(ev_data), 0);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    reg_addr = 3'(a);
    #0.5;
    d = int'(reg_rdata);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
  end

  initial begin
    int v, base, ratio, n, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk(v == 0, "R1 register reset value", v, 0);
    end
    chk(mem_rd == 1'b0, "R1 no fetch after reset", int'(mem_rd), 0);
    chk(ev_valid == 1'b0, "R1 no event after reset", int'(ev_valid), 0);

    // sweep: entries code x ratio
    for (int code = 0; code < 3; code++) begin
      for (int ri = 0; ri < 4; ri++) begin
        ratio = (1 << ri) - 1;
        base  = 12'h100 + code * 16 + ri;
        wr(2, (code << 12) | base);
        wr(3, (2 << 8) | 1);
        wr(4, ratio);
        model_start(base, code, 2, 1, ratio);
        wr(0, 1);
        if (code == 0 && ri == 0) begin
          // R11 writes ignored while enabled
          wr(2, 16'h2ABC);
          rd(2, v);
          chk(v == ((code << 12) | base), "R11 table locked", v, (code << 12) | base);
          wr(3, 16'h0707);
          rd(3, v);
          chk(v == 16'h0201, "R11 ends locked", v, 16'h0201);
          wr(4, 7);
          rd(4, v);
          chk(v == 0, "R11 ratio locked", v, 0);
        end
        if (ratio == 0) n = 6 * (8 << code) + 4;
        else n = ratio * 3 * (8 << code) + 2 * (8 << code) + 3 * (8 << code);
        while (rd_count < n) @(negedge clk);
        wr(0, 0);
        c0 = rd_count;
        repeat (12) @(negedge clk);
        chk(rd_count - c0 <= 1, "R12 fetch stops after disable", rd_count - c0, 1);
        chk(qh == qt, "R7 all active entries delivered", qh, qt);
      end
    end

    // R8 overload with stalled output
    all_active = 1'b1; chk_ev = 1'b0; ev_ready = 1'b0;
    wr(2, 16'h0010);
    wr(4, 0);
    model_start(16'h010, 0, 2, 1, 0);
    wr(0, 1);
    repeat (20) @(negedge clk);
    wr(0, 0);
    repeat (8) @(negedge clk);
    chk(ev_valid == 1'b1, "R7 stalled event held", int'(ev_valid), 1);
    chk(ev_data == 15'h2000, "R8 later events dropped", int'(ev_data), 16'h2000);
    rd(1, v);
    chk((v & 1) == 1, "R8 overload flag set", v & 1, 1);
    chk((v >> 15) == 1, "R9 service with overload", v >> 15, 1);
    ev_ready = 1'b1;
    @(negedge clk);
    chk(ev_valid == 1'b0, "R7 event released on ready", int'(ev_valid), 0);
    rd(1, v);
    chk((v & 1) == 1, "R8 flag survives consume", v & 1, 1);
    wr(1, 1);
    rd(1, v);
    chk(v == 0, "R8 R9 flag cleared by writing 1", v, 0);
    all_active = 1'b0; chk_ev = 1'b1;

    // R10 configuration errors
    wr(2, (3 << 12) | 16'h020);
    wr(0, 1);
    rd(0, v);
    chk(v == 0, "R10 reserved code refused", v, 0);
    rd(1, v);
    chk(v == 16'h8002, "R10 R9 config flag and service", v, 16'h8002);
    c0 = rd_count;
    repeat (10) @(negedge clk);
    chk(rd_count == c0, "R10 no fetch when refused", rd_count - c0, 0);
    wr(1, 2);
    rd(1, v);
    chk(v == 0, "R10 config flag cleared", v, 0);
    wr(2, 16'h020);
    wr(4, 2);
    wr(0, 1);
    rd(0, v);
    chk(v == 0, "R10 ratio 2 refused", v, 0);
    rd(1, v);
    chk(v == 16'h8002, "R10 ratio flag", v, 16'h8002);
    wr(1, 2);
    rd(1, v);
    chk(v == 0, "R10 flag cleared again", v, 0);

    summary();
  end
endmodule